// File: doc/BRIEF.md
# Shared-Term Programmable AND-OR Array

This block is a two-level programmable logic array. A configurable AND plane builds product terms from the array inputs, and each input is offered to every product term in both true and inverted form. A configurable OR plane then builds sum terms. Any product term can drive any number of sum terms, so logic common to several functions is built once and shared rather than copied. The default size is 38 inputs, 67 product terms and 50 sum terms. Sum terms are grouped four to a logic cell: sum term `s` is slot `s % 4` of cell `s / 4`.

The configuration is held in flip-flops. It is written through a serial shift chain clocked by `cfg_clk`. Inputs to outputs is a purely combinational path, so every sum term is one AND-OR level deep. This depth is enough for wide functions such as a 16-bit equality compare built from 32 shared product terms. Every product term and every sum term is brought out, so that neighbouring control logic can use them.

Top module: `pla_shared_array`

## Requirements
- R1: A high `cfg_rst` at a rising `cfg_clk` clears every configuration bit. After that edge every `pt_out` bit is 1 and every `st_out` bit is 0, whatever `arr_in` is.
- R2: While `cfg_en` is high and `cfg_rst` is low, each rising `cfg_clk` takes in one bit from `cfg_din`. The chain holds 8442 bits. After 8442 shifts, the bit shifted k-th (counting from 0) sets configuration bit k. Bits 0 to 5091 form the AND plane, so they are shifted first. Bits 5092 to 8441 form the OR plane.
- R3: While `cfg_en` is low, a `cfg_clk` edge does not change the configuration, whatever `cfg_din` is.
- R4: AND-plane bit k belongs to product term k/76, with j = k%76. Bit j=2i selects input i in true form and bit j=2i+1 selects it in complement form. A product term is the AND of its selected literals.
- R5: A product term with no literal selected is 1.
- R6: A product term that selects both forms of the same input is 0 for every input value.
- R7: OR-plane bit 5092+m connects product term m%67 to sum term m/67. A sum term is the OR of its connected product terms, and a sum term with no connection is 0.
- R8: One product term connected to several sum terms drives all of them at the same time.
- R9: `pt_out` and `st_out` follow a change of `arr_in` with no `cfg_clk` edge.
- R10: With 32 product terms holding the bitwise mismatches of two 16-bit words, and all 32 feeding one sum term, that sum term is 0 exactly when the two words are equal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| cfg_clk | input | 1 | Clock of the configuration chain |
| cfg_rst | input | 1 | Synchronous active-high clear of the configuration |
| cfg_en | input | 1 | Shift enable of the chain |
| cfg_din | input | 1 | Serial configuration data |
| arr_in | input | 38 | Array inputs |
| pt_out | output | 67 | Product-term values |
| st_out | output | 50 | Sum-term values |

## Verification
The array is first tried with an empty configuration, which shows whether reset leaves every product term at 1 and every sum term at 0. Next comes a short partial shift, which shows whether the first bits shifted in land in the top OR-plane positions. A sparse pseudo-random configuration is then driven with random, all-zero and all-one inputs, and the result is compared with a behavioural model. This pass tells a literal polarity error apart from a plane indexing error. A comparator configuration with equal words and with words that differ in the low or high half separates shared product terms from duplicated ones. This pass also shows that conflicting literals give 0 and that empty terms give 1 or 0.

// File: rtl/pla_pkg.sv
package pla_pkg;

    localparam int PLA_N_IN  = 38;
    localparam int PLA_N_PT  = 67;
    localparam int PLA_N_ST  = 50;
    localparam int PLA_GROUP = 4;

    typedef enum logic {
        POL_TRUE = 1'b0,
        POL_COMP = 1'b1
    } pol_e;

    function automatic int lit_pos(input int in_idx, input pol_e pol);
        return 2 * in_idx + ((pol == POL_COMP) ? 1 : 0);
    endfunction

    function automatic int and_bits(input int n_in, input int n_pt);
        return 2 * n_in * n_pt;
    endfunction

    function automatic int or_bits(input int n_pt, input int n_st);
        return n_pt * n_st;
    endfunction

    function automatic int cell_of(input int st_idx);
        return st_idx / PLA_GROUP;
    endfunction

endpackage

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= {din, q[W-1:1]};
        end
    end
endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane
    import pla_pkg::*;
#(
    parameter int N_IN = PLA_N_IN,
    parameter int N_PT = PLA_N_PT,
    localparam int LIT_W = 2 * N_IN
) (
    input  logic [N_IN-1:0]        arr_in,
    input  logic [N_PT*LIT_W-1:0]  sel,
    output logic [N_PT-1:0]        pt
);
    logic [LIT_W-1:0] lits;

    always_comb begin
        for (int i = 0; i < N_IN; i++) begin
            lits[lit_pos(i, POL_TRUE)] = arr_in[i];
            lits[lit_pos(i, POL_COMP)] = ~arr_in[i];
        end
    end

    for (genvar p = 0; p < N_PT; p++) begin : g_pt
        logic [LIT_W-1:0] row;
        assign row   = sel[p*LIT_W +: LIT_W];
        assign pt[p] = &(lits | ~row);
    end
endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane
    import pla_pkg::*;
#(
    parameter int N_PT = PLA_N_PT,
    parameter int N_ST = PLA_N_ST
) (
    input  logic [N_PT-1:0]       pt,
    input  logic [N_ST*N_PT-1:0]  sel,
    output logic [N_ST-1:0]       st
);
    for (genvar s = 0; s < N_ST; s++) begin : g_st
        logic [N_PT-1:0] conn;
        assign conn  = sel[s*N_PT +: N_PT];
        assign st[s] = |(conn & pt);
    end
endmodule

// File: rtl/pla_shared_array.sv
module pla_shared_array
    import pla_pkg::*;
#(
    parameter int N_IN = PLA_N_IN,
    parameter int N_PT = PLA_N_PT,
    parameter int N_ST = PLA_N_ST,
    localparam int AND_W = 2 * N_IN * N_PT,
    localparam int OR_W  = N_PT * N_ST,
    localparam int CFG_W = AND_W + OR_W
) (
    input  logic            cfg_clk,
    input  logic            cfg_rst,
    input  logic            cfg_en,
    input  logic            cfg_din,
    input  logic [N_IN-1:0] arr_in,
    output logic [N_PT-1:0] pt_out,
    output logic [N_ST-1:0] st_out
);
    logic [CFG_W-1:0] cfg_q;

    pla_cfg_chain #(.W(CFG_W)) u_chain (
        .clk (cfg_clk),
        .rst (cfg_rst),
        .en  (cfg_en),
        .din (cfg_din),
        .q   (cfg_q)
    );

    pla_and_plane #(.N_IN(N_IN), .N_PT(N_PT)) u_and (
        .arr_in (arr_in),
        .sel    (cfg_q[AND_W-1:0]),
        .pt     (pt_out)
    );

    pla_or_plane #(.N_PT(N_PT), .N_ST(N_ST)) u_or (
        .pt  (pt_out),
        .sel (cfg_q[CFG_W-1:AND_W]),
        .st  (st_out)
    );
endmodule

// File: rtl/pla_shared_array_chk.sv
module pla_shared_array_chk #(
    parameter int N_IN = 38,
    parameter int N_PT = 67,
    parameter int N_ST = 50,
    localparam int LIT_W = 2 * N_IN,
    localparam int AND_W = LIT_W * N_PT,
    localparam int CFG_W = AND_W + N_PT * N_ST
) (
    input logic             cfg_clk,
    input logic             cfg_rst,
    input logic             cfg_en,
    input logic             cfg_din,
    input logic [N_IN-1:0]  arr_in,
    input logic [N_PT-1:0]  pt_out,
    input logic [N_ST-1:0]  st_out,
    input logic [CFG_W-1:0] cfg_q
);
    // R1: clear on reset
    a_r1_reset_clears: assert property (@(posedge cfg_clk)
        cfg_rst |=> (cfg_q == '0 && st_out == '0 && (&pt_out)));

    // R2: one bit enters at the top, the rest move down
    a_r2_shift_in: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
        cfg_en |=> (cfg_q[CFG_W-1] == $past(cfg_din)
                    && cfg_q[CFG_W-2:0] == $past(cfg_q[CFG_W-1:1])));

    // R3: no shift, steady inputs -> steady outputs
    a_r3_hold: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
        !cfg_en |=> ($stable(arr_in) -> ($stable(pt_out) && $stable(st_out))));

    for (genvar p = 0; p < N_PT; p++) begin : g_pt_chk
        // R5: empty product term is 1
        a_r5_empty_pt: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
            (cfg_q[p*LIT_W +: LIT_W] == '0) |-> pt_out[p]);
    end

    for (genvar s = 0; s < N_ST; s++) begin : g_st_chk
        // R7: unconnected sum term is 0
        a_r7_empty_sum: assert property (@(posedge cfg_clk) disable iff (cfg_rst)
            (cfg_q[AND_W + s*N_PT +: N_PT] == '0) |-> !st_out[s]);
    end
endmodule

bind pla_shared_array pla_shared_array_chk #(
    .N_IN(N_IN), .N_PT(N_PT), .N_ST(N_ST)
) u_chk (
    .cfg_clk (cfg_clk),
    .cfg_rst (cfg_rst),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .arr_in  (arr_in),
    .pt_out  (pt_out),
    .st_out  (st_out),
    .cfg_q   (cfg_q)
);

// File: tb/pla_shared_array_tb.sv
module pla_shared_array_tb;
    localparam int NI = 38;
    localparam int NP = 67;
    localparam int NS = 50;
    localparam int AW = 2 * NI * NP;
    localparam int TW = AW + NP * NS;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en  = 1'b0;
    logic          sdin = 1'b0;
    logic [NI-1:0] ain = '0;
    logic [NP-1:0] pt_out;
    logic [NS-1:0] st_out;

    always #2.5 clk = ~clk;

    pla_shared_array u_dut (
        .cfg_clk (clk), .cfg_rst (rst), .cfg_en (en), .cfg_din (sdin),
        .arr_in (ain), .pt_out (pt_out), .st_out (st_out)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;
    string tag = "R1";
    bit mq[$];
    bit img[TW];
    logic [NP-1:0] ept;
    logic [NS-1:0] est;
    int unsigned seed = 32'h1ACE5EED;

    function automatic int unsigned rnd();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    function automatic logic [NI-1:0] rnd_in();
        logic [63:0] v;
        v = {rnd(), rnd()};
        return v[NI-1:0];
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        mq.delete();
        for (int k = 0; k < TW; k++) mq.push_back(1'b0);
    endtask

    task automatic calc();
        for (int p = 0; p < NP; p++) begin
            ept[p] = 1'b1;
            for (int i = 0; i < NI; i++) begin
                if (mq[p*2*NI + 2*i] && !ain[i]) ept[p] = 1'b0;
                if (mq[p*2*NI + 2*i + 1] && ain[i]) ept[p] = 1'b0;
            end
        end
        for (int s = 0; s < NS; s++) begin
            est[s] = 1'b0;
            for (int p = 0; p < NP; p++)
                if (mq[AW + s*NP + p] && ept[p]) est[s] = 1'b1;
        end
    endtask

    task automatic step(input bit r, input bit e, input bit d, input logic [NI-1:0] a);
        rst = r; en = e; sdin = d; ain = a;
        @(posedge clk);
        if (r) model_reset();
        else if (e) begin
            mq.push_back(d);
            void'(mq.pop_front());
        end
        #1;
        calc();
        chk(tag, "pt_out per clock", {61'b0, pt_out}, {61'b0, ept});
        chk(tag, "st_out per clock", {78'b0, st_out}, {78'b0, est});
    endtask

    task automatic load_img();
        for (int k = 0; k < TW; k++) step(1'b0, 1'b1, img[k], rnd_in());
    endtask

    task automatic clr_img();
        for (int k = 0; k < TW; k++) img[k] = 1'b0;
    endtask

    function automatic logic [NI-1:0] cmp_in(input logic [15:0] a, input logic [15:0] b);
        logic [NI-1:0] v;
        v = '0;
        v[15:0]  = a;
        v[31:16] = b;
        return v;
    endfunction

    initial begin
        model_reset();
        // R1: reset state under varied inputs
        tag = "R1";
        step(1, 0, 0, '0);
        step(1, 0, 1, '1);
        chk("R1", "pt all ones after reset", {61'b0, pt_out}, {61'b0, {NP{1'b1}}});
        chk("R1", "st all zero after reset", {78'b0, st_out}, 128'b0);
        step(0, 0, 0, rnd_in());
        chk("R1", "st zero on random input", {78'b0, st_out}, 128'b0);

        // R2: partial shift of ones lands at top OR positions
        tag = "R2";
        for (int k = 0; k < 100; k++) step(0, 1, 1, rnd_in());
        step(0, 0, 0, rnd_in());
        chk("R2", "st49 fed by empty terms", {127'b0, st_out[49]}, 128'd1);
        chk("R2", "st48 fed by empty terms", {127'b0, st_out[48]}, 128'd1);
        chk("R2", "st47 untouched", {127'b0, st_out[47]}, 128'd0);

        // R4 / R7: sparse pseudo-random configuration
        tag = "R4";
        for (int k = 0; k < AW; k++) begin
            int unsigned r;
            r = rnd();
            img[k] = ((k / (2*NI)) % 3 == 0) ? (r[11:6] == 0) : (r[9:6] == 0);
        end
        for (int k = AW; k < TW; k++) begin
            int unsigned r;
            r = rnd();
            img[k] = (r[10:8] == 0);
        end
        load_img();
        tag = "R7";
        step(0, 0, 0, '0);
        step(0, 0, 0, '1);
        for (int n = 0; n < 300; n++) step(0, 0, rnd() % 2, rnd_in());

        // R9: outputs follow inputs without a clock edge
        ain = ~ain;
        #1;
        calc();
        chk("R9", "pt after input change", {61'b0, pt_out}, {61'b0, ept});
        chk("R9", "st after input change", {78'b0, st_out}, {78'b0, est});

        // R1: mid-run reset
        tag = "R1";
        step(1, 0, 0, rnd_in());
        chk("R1", "st zero after mid reset", {78'b0, st_out}, 128'b0);
        chk("R1", "pt ones after mid reset", {61'b0, pt_out}, {61'b0, {NP{1'b1}}});
        step(0, 0, 0, rnd_in());

        // R10 comparator with shared mismatch terms
        clr_img();
        for (int i = 0; i < 16; i++) begin
            img[(2*i)*2*NI + 2*i]            = 1'b1; // a_i true
            img[(2*i)*2*NI + 2*(16+i) + 1]   = 1'b1; // b_i comp
            img[(2*i+1)*2*NI + 2*i + 1]      = 1'b1; // a_i comp
            img[(2*i+1)*2*NI + 2*(16+i)]     = 1'b1; // b_i true
        end
        img[40*2*NI + 2*5]     = 1'b1; // R6 conflict
        img[40*2*NI + 2*5 + 1] = 1'b1;
        for (int p = 0; p < 32; p++) img[AW + 0*NP + p] = 1'b1;
        for (int p = 0; p < 16; p++) img[AW + 1*NP + p] = 1'b1;
        img[AW + 2*NP + 41] = 1'b1;
        img[AW + 4*NP + 40] = 1'b1;
        tag = "R2";
        load_img();
        tag = "R10";
        step(0, 0, 0, cmp_in(16'h1234, 16'h1234));
        chk("R10", "equal words", {127'b0, st_out[0]}, 128'd0);
        chk("R8", "shared low half equal", {127'b0, st_out[1]}, 128'd0);
        chk("R6", "conflict pt", {127'b0, pt_out[40]}, 128'd0);
        chk("R6", "conflict st", {127'b0, st_out[4]}, 128'd0);
        chk("R5", "empty pt", {127'b0, pt_out[41]}, 128'd1);
        chk("R5", "st fed by empty pt", {127'b0, st_out[2]}, 128'd1);
        chk("R7", "unconnected st", {127'b0, st_out[3]}, 128'd0);
        step(0, 0, 0, cmp_in(16'h1234, 16'h1235));
        chk("R10", "low bit differs", {127'b0, st_out[0]}, 128'd1);
        chk("R8", "shared pt drives both", {126'b0, st_out[1:0]}, 128'd3);
        step(0, 0, 0, cmp_in(16'h0000, 16'h8000));
        chk("R10", "high bit differs", {127'b0, st_out[0]}, 128'd1);
        chk("R8", "low half sum stays 0", {127'b0, st_out[1]}, 128'd0);
        step(0, 0, 0, cmp_in(16'hFFFF, 16'hFFFF) | 38'h20_0000_0000);
        chk("R10", "all ones equal", {127'b0, st_out[0]}, 128'd0);
        chk("R6", "conflict pt with in5 high", {127'b0, pt_out[40]}, 128'd0);
        for (int n = 0; n < 40; n++) step(0, 0, 0, rnd_in());

        // R3: hold with garbage on cfg_din
        begin
            logic [NP-1:0] pt0;
            logic [NS-1:0] st0;
            tag = "R3";
            step(0, 0, 0, cmp_in(16'hA5A5, 16'hA5A4));
            pt0 = pt_out; st0 = st_out;
            for (int n = 0; n < 30; n++) step(0, 0, rnd() % 2, cmp_in(16'hA5A5, 16'hA5A4));
            chk("R3", "pt held", {61'b0, pt_out}, {61'b0, pt0});
            chk("R3", "st held", {78'b0, st_out}, {78'b0, st0});
        end

        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule